// File: doc/BRIEF.md
# Multi-Port SATA Interrupt Aggregation Unit

This block gathers every interrupt source of four SATA ports into one 32-bit read-only summary word. Each port owns one byte of that word. For each port the block keeps a small error register. Error-event strobes from the link and transport layers set its bits, and software clears them by writing ones. Each port also has a device interrupt flag in the IDE-compatible style. A device-to-host register FIS carrying its interrupt bit sets the flag, and a read of that port's taskfile status address clears it.

The summary word is a view only. A write to it changes nothing. Software clears a pending cause where it is stored: in the port's error register, or by reading that port's status address. A registered combined interrupt line is asserted whenever any summary bit is set. The block is reached through a simple word-addressed bus: write enable, read enable, address and 32-bit data. Read data is combinational from the address while the read enable is high.

Top module: `sata_irq_agg`

## Requirements
- R1: After reset the summary word, every error register, every device interrupt flag and `irqOut` are all 0.
- R2: The summary word is read at address 0. Port n owns bits 8n+7..8n. Bit 8n+7 is the device interrupt flag. The error flags follow, each mirroring one error-register bit: bit 8n+6 is CRC (error bit 21), bit 8n+5 is data integrity (error bit 8), bit 8n+4 is unrecognized FIS (error bit 10), bit 8n+3 is R_ERR received (error bit 22) and bit 8n+2 is FIFO error (error bit 11). Bits 8n+1 and 8n+0 read as 0.
- R3: Strobe `errEvent[5n+k]` for k = 0,1,2,3,4 sets, at the next clock edge, error bit 21, 8, 10, 22 or 11 respectively of port n. Reading address 4+n returns that port's error register, with those bits at those positions and all other bits 0.
- R4: A write to address 4+n clears each of the five error bits whose data bit is 1. Error bits whose data bit is 0 are unchanged, and the other ports are unaffected.
- R5: If an error event and a write-one-to-clear hit the same error bit in the same cycle, the bit stays set.
- R6: `fisIrq[n]` sets the device interrupt flag of port n at the next edge. A read of address 8+n clears it at the next edge, and that read returns 0.
- R7: If `fisIrq[n]` and a read of address 8+n occur in the same cycle, the device interrupt flag of port n stays set.
- R8: A write to address 0 leaves the summary word unchanged.
- R9: `irqOut` is the OR of all summary bits, registered, so it follows a change of the summary word one clock later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| regAddr | input | 4 | Word address of the register access |
| regWrEn | input | 1 | Write strobe |
| regRdEn | input | 1 | Read strobe (status addresses have a clearing side effect) |
| regWrData | input | 32 | Write data |
| regRdData | output | 32 | Read data, combinational, 0 when no read is active |
| errEvent | input | 20 | Error event strobes, 5 per port, bit 5n+k |
| fisIrq | input | 4 | Per-port strobe: register FIS with interrupt bit received |
| irqOut | output | 1 | Registered combined interrupt |

## Verification
The hardest cases to reach are the same-cycle collisions. One is an error event landing in the very cycle that software writes a one to clear that bit. The other is a FIS interrupt arriving in the same cycle as the status read that would clear it. At the ports these happen only when both strobes are held through one shared clock edge. The bench drives both together in a single low phase and then reads the summary word back. A table of single-operation vectors walks the summary word through sets, partial clears and ignored writes. After each vector it checks `irqOut` both before and after its one-cycle lag.

// File: rtl/sata_irq_pkg.sv
package sata_irq_pkg;

  localparam int NUM_PORTS    = 4;
  localparam int EVT_PER_PORT = 5;
  localparam int DATA_W       = 32;
  localparam int ADDR_W       = 4;
  localparam int BYTE_W       = DATA_W / NUM_PORTS;
  localparam int PORT_IDX_W   = $clog2(NUM_PORTS);
  localparam int EVT_W        = NUM_PORTS * EVT_PER_PORT;

  // Word addresses of the register windows
  localparam int PEND_ADDR = 0;
  localparam int ERR_BASE  = 4;
  localparam int STAT_BASE = 8;

  // Error-register bit that event k of a port sets; the summary bit of
  // event k sits at BYTE_W-2-k inside the port's byte.
  localparam int ERR_POS [EVT_PER_PORT] = '{21, 8, 10, 22, 11};

  typedef enum logic [1:0] {
    RD_ZERO = 2'd0,
    RD_PEND = 2'd1,
    RD_ERR  = 2'd2
  } rdSrcE;

  typedef struct packed {
    logic [NUM_PORTS-1:0]  errWrSel;
    logic [NUM_PORTS-1:0]  statRdSel;
    rdSrcE                 rdSrc;
    logic [PORT_IDX_W-1:0] rdPort;
  } ctlStrobeT;

endpackage

// File: rtl/sata_irq_ctrl.sv
module sata_irq_ctrl
  import sata_irq_pkg::*;
(
  input  logic [ADDR_W-1:0] regAddr,
  input  logic              regWrEn,
  input  logic              regRdEn,
  output ctlStrobeT         strobes
);

  logic [NUM_PORTS-1:0] errHit;
  logic [NUM_PORTS-1:0] statHit;
  logic                 pendHit;

  assign pendHit = (regAddr == ADDR_W'(PEND_ADDR));

  for (genvar p = 0; p < NUM_PORTS; p++) begin : g_dec
    assign errHit[p]  = (regAddr == ADDR_W'(ERR_BASE + p));
    assign statHit[p] = (regAddr == ADDR_W'(STAT_BASE + p));
  end

  always_comb begin
    strobes.errWrSel  = errHit & {NUM_PORTS{regWrEn}};
    strobes.statRdSel = statHit & {NUM_PORTS{regRdEn}};
    strobes.rdSrc     = RD_ZERO;
    strobes.rdPort    = '0;
    if (regRdEn) begin
      if (pendHit) begin
        strobes.rdSrc = RD_PEND;
      end else if (|errHit) begin
        strobes.rdSrc  = RD_ERR;
        strobes.rdPort = PORT_IDX_W'(regAddr - ADDR_W'(ERR_BASE));
      end
    end
  end

endmodule

// File: rtl/sata_irq_dp.sv
module sata_irq_dp
  import sata_irq_pkg::*;
(
  input  logic               clk,
  input  logic               rstN,
  input  ctlStrobeT          strobes,
  input  logic [DATA_W-1:0]  regWrData,
  input  logic [EVT_W-1:0]   errEvent,
  input  logic [NUM_PORTS-1:0] fisIrq,
  output logic [DATA_W-1:0]  regRdData,
  output logic [DATA_W-1:0]  pendVec,
  output logic               irqOut
);

  logic [DATA_W-1:0] errImage [NUM_PORTS];

  for (genvar p = 0; p < NUM_PORTS; p++) begin : g_port
    logic [EVT_PER_PORT-1:0] errFlags;
    logic [EVT_PER_PORT-1:0] evtIn;
    logic [EVT_PER_PORT-1:0] clrMask;
    logic                    devIrq;
    logic [BYTE_W-1:0]       byteView;
    logic [DATA_W-1:0]       imgView;

    assign evtIn = errEvent[p*EVT_PER_PORT +: EVT_PER_PORT];

    always_comb begin
      for (int k = 0; k < EVT_PER_PORT; k++) begin
        clrMask[k] = strobes.errWrSel[p] & regWrData[ERR_POS[k]];
      end
    end

    // Set has priority over a same-cycle clear
    always_ff @(posedge clk) begin
      if (!rstN) begin
        errFlags <= '0;
      end else begin
        errFlags <= (errFlags & ~clrMask) | evtIn;
      end
    end

    // FIS interrupt has priority over a same-cycle status read
    always_ff @(posedge clk) begin
      if (!rstN) begin
        devIrq <= 1'b0;
      end else begin
        devIrq <= fisIrq[p] | (devIrq & ~strobes.statRdSel[p]);
      end
    end

    always_comb begin
      byteView = '0;
      byteView[BYTE_W-1] = devIrq;
      for (int k = 0; k < EVT_PER_PORT; k++) begin
        byteView[BYTE_W-2-k] = errFlags[k];
      end
    end

    always_comb begin
      imgView = '0;
      for (int k = 0; k < EVT_PER_PORT; k++) begin
        imgView[ERR_POS[k]] = errFlags[k];
      end
    end

    assign pendVec[p*BYTE_W +: BYTE_W] = byteView;
    assign errImage[p] = imgView;
  end

  always_comb begin
    case (strobes.rdSrc)
      RD_PEND: regRdData = pendVec;
      RD_ERR:  regRdData = errImage[strobes.rdPort];
      default: regRdData = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      irqOut <= 1'b0;
    end else begin
      irqOut <= |pendVec;
    end
  end

endmodule

// File: rtl/sata_irq_agg.sv
module sata_irq_agg
  import sata_irq_pkg::*;
(
  input  logic                 clk,
  input  logic                 rstN,
  input  logic [ADDR_W-1:0]    regAddr,
  input  logic                 regWrEn,
  input  logic                 regRdEn,
  input  logic [DATA_W-1:0]    regWrData,
  output logic [DATA_W-1:0]    regRdData,
  input  logic [EVT_W-1:0]     errEvent,
  input  logic [NUM_PORTS-1:0] fisIrq,
  output logic                 irqOut
);

  ctlStrobeT         strobes;
  logic [DATA_W-1:0] pendVec;

  sata_irq_ctrl u_ctrl (
    .regAddr (regAddr),
    .regWrEn (regWrEn),
    .regRdEn (regRdEn),
    .strobes (strobes)
  );

  sata_irq_dp u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .strobes   (strobes),
    .regWrData (regWrData),
    .errEvent  (errEvent),
    .fisIrq    (fisIrq),
    .regRdData (regRdData),
    .pendVec   (pendVec),
    .irqOut    (irqOut)
  );

endmodule

// File: rtl/sata_irq_agg_chk.sv
module sata_irq_agg_chk
  import sata_irq_pkg::*;
(
  input logic                 clk,
  input logic                 rstN,
  input logic [ADDR_W-1:0]    regAddr,
  input logic                 regWrEn,
  input logic                 regRdEn,
  input logic [DATA_W-1:0]    regWrData,
  input logic [DATA_W-1:0]    regRdData,
  input logic [EVT_W-1:0]     errEvent,
  input logic [NUM_PORTS-1:0] fisIrq,
  input logic                 irqOut,
  input logic [DATA_W-1:0]    pendVec
);

  AST_PEND_READ: assert property (@(posedge clk) disable iff (!rstN)
    (regRdEn && regAddr == ADDR_W'(PEND_ADDR)) |-> regRdData == pendVec); // R2

  AST_IRQ_LAG: assert property (@(posedge clk) disable iff (!rstN)
    1'b1 |=> irqOut == $past(|pendVec)); // R9

  AST_PEND_RO: assert property (@(posedge clk) disable iff (!rstN)
    (regWrEn && regAddr == ADDR_W'(PEND_ADDR) && !regRdEn && errEvent == '0 && fisIrq == '0)
    |=> $stable(pendVec)); // R8

  for (genvar p = 0; p < NUM_PORTS; p++) begin : g_chk
    AST_FIS_SET: assert property (@(posedge clk) disable iff (!rstN)
      fisIrq[p] |=> pendVec[p*BYTE_W + BYTE_W-1]); // R6

    AST_STAT_CLR: assert property (@(posedge clk) disable iff (!rstN)
      (regRdEn && regAddr == ADDR_W'(STAT_BASE + p) && !fisIrq[p])
      |=> !pendVec[p*BYTE_W + BYTE_W-1]); // R6

    AST_FIS_WINS: assert property (@(posedge clk) disable iff (!rstN)
      (regRdEn && regAddr == ADDR_W'(STAT_BASE + p) && fisIrq[p])
      |=> pendVec[p*BYTE_W + BYTE_W-1]); // R7

    for (genvar k = 0; k < EVT_PER_PORT; k++) begin : g_bit
      AST_EVT_SET: assert property (@(posedge clk) disable iff (!rstN)
        errEvent[p*EVT_PER_PORT + k] |=> pendVec[p*BYTE_W + BYTE_W-2-k]); // R3

      AST_W0_KEEP: assert property (@(posedge clk) disable iff (!rstN)
        (regWrEn && regAddr == ADDR_W'(ERR_BASE + p) && !regWrData[ERR_POS[k]]
         && pendVec[p*BYTE_W + BYTE_W-2-k])
        |=> pendVec[p*BYTE_W + BYTE_W-2-k]); // R4

      AST_W1_CLR: assert property (@(posedge clk) disable iff (!rstN)
        (regWrEn && regAddr == ADDR_W'(ERR_BASE + p) && regWrData[ERR_POS[k]]
         && !errEvent[p*EVT_PER_PORT + k])
        |=> !pendVec[p*BYTE_W + BYTE_W-2-k]); // R4

      AST_SET_WINS: assert property (@(posedge clk) disable iff (!rstN)
        (regWrEn && regAddr == ADDR_W'(ERR_BASE + p) && regWrData[ERR_POS[k]]
         && errEvent[p*EVT_PER_PORT + k])
        |=> pendVec[p*BYTE_W + BYTE_W-2-k]); // R5
    end
  end

endmodule

bind sata_irq_agg sata_irq_agg_chk u_chk (
  .clk       (clk),
  .rstN      (rstN),
  .regAddr   (regAddr),
  .regWrEn   (regWrEn),
  .regRdEn   (regRdEn),
  .regWrData (regWrData),
  .regRdData (regRdData),
  .errEvent  (errEvent),
  .fisIrq    (fisIrq),
  .irqOut    (irqOut),
  .pendVec   (pendVec)
);

// File: tb/sata_irq_agg_bench.sv
module sata_irq_agg_bench;

  typedef struct packed {
    logic [2:0]  kind;     // 0 event, 1 fis, 2 error write, 3 status read, 4 summary write
    logic [1:0]  port;
    logic [31:0] data;
    logic [31:0] expPend;
  } vecT;

  localparam int NV = 13;
  localparam vecT VEC [NV] = '{
    '{3'd0, 2'd0, 32'h0000_0001, 32'h0000_0040},
    '{3'd0, 2'd1, 32'h0000_001E, 32'h0000_3C40},
    '{3'd1, 2'd2, 32'h0000_0000, 32'h0080_3C40},
    '{3'd2, 2'd1, 32'h0040_0100, 32'h0080_1440},
    '{3'd2, 2'd0, 32'hFFDF_FFFF, 32'h0080_1440},
    '{3'd3, 2'd2, 32'h0000_0000, 32'h0000_1440},
    '{3'd0, 2'd3, 32'h0000_0010, 32'h0400_1440},
    '{3'd1, 2'd3, 32'h0000_0000, 32'h8400_1440},
    '{3'd4, 2'd0, 32'hFFFF_FFFF, 32'h8400_1440},
    '{3'd2, 2'd3, 32'hFFFF_FFFF, 32'h8000_1440},
    '{3'd2, 2'd0, 32'h0020_0000, 32'h8000_1400},
    '{3'd2, 2'd1, 32'h0000_0C00, 32'h8000_0000},
    '{3'd3, 2'd3, 32'h0000_0000, 32'h0000_0000}
  };

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [3:0]  regAddr = '0;
  logic        regWrEn = 1'b0;
  logic        regRdEn = 1'b0;
  logic [31:0] regWrData = '0;
  logic [31:0] regRdData;
  logic [19:0] errEvent = '0;
  logic [3:0]  fisIrq = '0;
  logic        irqOut;

  int checks = 0;
  int failures = 0;
  bit finished = 1'b0;

  always #10 clk = ~clk;

  sata_irq_agg u_sata_irq_agg (
    .clk(clk), .rstN(rstN), .regAddr(regAddr), .regWrEn(regWrEn),
    .regRdEn(regRdEn), .regWrData(regWrData), .regRdData(regRdData),
    .errEvent(errEvent), .fisIrq(fisIrq), .irqOut(irqOut)
  );

  task automatic check32(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic readReg(input logic [3:0] addr, output logic [31:0] val);
    regAddr = addr;
    regRdEn = 1'b1;
    #1;
    val = regRdData;
    regRdEn = 1'b0;
    #1;
  endtask

  task automatic idle();
    regWrEn = 1'b0; regRdEn = 1'b0; errEvent = '0; fisIrq = '0; regWrData = '0;
  endtask

  task automatic applyOp(input vecT v);
    case (v.kind)
      3'd0: errEvent[5*v.port +: 5] = v.data[4:0];
      3'd1: fisIrq[v.port] = 1'b1;
      3'd2: begin regWrEn = 1'b1; regAddr = 4'(4 + v.port); regWrData = v.data; end
      3'd3: begin regRdEn = 1'b1; regAddr = 4'(8 + v.port); end
      default: begin regWrEn = 1'b1; regAddr = 4'd0; regWrData = v.data; end
    endcase
    @(negedge clk);
    idle();
  endtask

  function automatic string tagOf(input logic [2:0] kind);
    case (kind)
      3'd0: return "R3 event set";
      3'd1: return "R6 fis set";
      3'd2: return "R4 w1c";
      3'd3: return "R6 status clear";
      default: return "R8 summary write ignored";
    endcase
  endfunction

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      failures++;
      $display("FAIL watchdog: actual=timeout expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    logic [31:0] rd;
    logic [31:0] prevExp;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // R1: reset state
    readReg(4'd0, rd);
    check32("R1 summary", rd, 32'h0);
    check32("R1 irqOut", {31'b0, irqOut}, 32'h0);
    for (int p = 0; p < 4; p++) begin
      readReg(4'(4 + p), rd);
      check32("R1 error reg", rd, 32'h0);
    end

    // Vector table: one operation each, then summary and irq lag checks (R2, R9)
    prevExp = 32'h0;
    for (int i = 0; i < NV; i++) begin
      applyOp(VEC[i]);
      readReg(4'd0, rd);
      check32(tagOf(VEC[i].kind), rd, VEC[i].expPend);
      check32("R9 irq before lag", {31'b0, irqOut}, {31'b0, |prevExp});
      @(negedge clk);
      check32("R9 irq after lag", {31'b0, irqOut}, {31'b0, |VEC[i].expPend});
      prevExp = VEC[i].expPend;
    end

    // R3: error register image for all five events on port 2
    errEvent[14:10] = 5'h1F;
    @(negedge clk); idle();
    readReg(4'd6, rd);
    check32("R3 error image", rd, 32'h0060_0D00);
    readReg(4'd0, rd);
    check32("R2 summary byte 2", rd, 32'h007C_0000);
    regWrEn = 1'b1; regAddr = 4'd6; regWrData = 32'hFFFF_FFFF;
    @(negedge clk); idle();
    readReg(4'd6, rd);
    check32("R4 clear all", rd, 32'h0);

    // R5: same-cycle event and clear of CRC on port 1
    errEvent[5] = 1'b1;
    regWrEn = 1'b1; regAddr = 4'd5; regWrData = 32'h0020_0000;
    @(negedge clk); idle();
    readReg(4'd0, rd);
    check32("R5 set wins", rd, 32'h0000_4000);
    regWrEn = 1'b1; regAddr = 4'd5; regWrData = 32'h0020_0000;
    @(negedge clk); idle();
    readReg(4'd0, rd);
    check32("R4 clear after collision", rd, 32'h0);

    // R7: same-cycle FIS interrupt and status read on port 0
    fisIrq[0] = 1'b1;
    regRdEn = 1'b1; regAddr = 4'd8;
    #1;
    check32("R6 status read data", regRdData, 32'h0);
    @(negedge clk); idle();
    readReg(4'd0, rd);
    check32("R7 fis wins", rd, 32'h0000_0080);
    regRdEn = 1'b1; regAddr = 4'd8;
    @(negedge clk); idle();
    readReg(4'd0, rd);
    check32("R6 later status clear", rd, 32'h0);

    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule